// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Manual Setting

This block keeps the time of day as three two-digit BCD fields: hours, minutes and seconds. It runs on a single system clock. A reference enable input pulses for one cycle at each edge of a 32768 Hz timebase. An internal binary prescaler divides those pulses by 2^PRESC_BITS (2^15 by default) to form the once-per-second advance. The digits leave the block as one packed 24-bit vector for a downstream display decoder. A one-cycle strobe marks every change of the seconds value.

The time is corrected with a run/set level input and two raw push buttons, one for minutes and one for hours. While set mode is held, seconds keep counting, but the carry from seconds into minutes and from minutes into hours is cut. Each button is synchronised and debounced, and each accepted press adds exactly one count to its own field. A wrap caused by a press stays inside that field. In run mode both buttons have no effect.

Top module: `bcd_tod_counter`

## Requirements
- R1: A synchronous reset sets the time to 00:00:00, clears the prescaler and the debouncers, and holds secStrobe low.
- R2: The seconds field advances by one on every 2^PRESC_BITS-th refEn pulse after reset. Fewer pulses leave the time unchanged.
- R3: secStrobe is high for exactly one cycle: the first cycle in which a new seconds value is visible on timeBcd. In every other cycle the seconds digits hold their value.
- R4: Seconds count 00 to 59. In run mode, the step from 59 to 00 advances minutes by one.
- R5: Minutes count 00 to 59. In run mode, a minute wrap caused by a seconds carry advances hours by one.
- R6: Hours count 00 to 23 and wrap to 00.
- R7: timeBcd holds six 8421 BCD digits. Bits [23:20] are hour tens, [19:16] hour units, [15:12] minute tens, [11:8] minute units, [7:4] second tens and [3:0] second units. Each digit always stays in its legal range.
- R8: While setMode is 1, seconds keep counting, but a seconds wrap does not change minutes and a minute wrap does not change hours.
- R9: In set mode, each accepted press of btnMinRaw adds one to minutes. A press that takes minutes from 59 to 00 leaves hours unchanged.
- R10: In set mode, each accepted press of btnHourRaw adds one to hours, and 23 wraps to 00.
- R11: A button is read through a two-flop synchroniser and is accepted only after it has held a new level for DEBOUNCE_CYCLES consecutive clocks. Shorter chatter makes no count, and a bouncing press makes exactly one count.
- R12: While setMode is 0, presses of either button leave the time unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refEn | input | 1 | One-cycle pulse per 32768 Hz reference edge |
| setMode | input | 1 | 0 = run, 1 = set (carries cut, buttons enabled) |
| btnMinRaw | input | 1 | Raw minute-advance button, active high |
| btnHourRaw | input | 1 | Raw hour-advance button, active high |
| timeBcd | output | 24 | Packed BCD time, layout as in R7 |
| secStrobe | output | 1 | One-cycle pulse when the seconds value changes |

## Verification
Several properties are checked on every cycle: digit legality, the pairing of secStrobe with a change of the seconds digits, the frozen minute and hour fields in set mode when no press arrives, the frozen time in run mode between second ticks, and the one-cycle width of the internal press pulses. Other behaviour can only be shown by the bench's scenarios. This covers the exact refEn count per second, the counting sequences across every seconds and minutes value with the carries into minutes and hours, the midnight wrap, the response to presses in each mode, and the rejection of short chatter.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Strobes handed from control to the counting datapath
  typedef struct packed {
    logic secTick;    // one-second advance
    logic minPress;   // accepted minute press, set mode only
    logic hourPress;  // accepted hour press, set mode only
    logic carryEn;    // 1 = ripple carries allowed (run mode)
  } todStrobe_t;

  // Advance a two-digit BCD value, wrapping to 00 after lastVal
  function automatic logic [7:0] bcdStep(input logic [7:0] cur, input logic [7:0] lastVal);
    logic [7:0] nxt;
    if (cur == lastVal) begin
      nxt = 8'h00;
    end else if (cur[3:0] == 4'd9) begin
      nxt = {cur[7:4] + 4'd1, 4'd0};
    end else begin
      nxt = {cur[7:4], cur[3:0] + 4'd1};
    end
    return nxt;
  endfunction

endpackage

// File: rtl/tod_debounce.sv
module tod_debounce #(
  parameter int DEBOUNCE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [1:0]       syncQ;
  logic             stableLvl;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ      <= '0;
      stableLvl  <= 1'b0;
      holdCnt    <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncQ      <= {syncQ[0], btnRaw};
      pressPulse <= 1'b0;
      if (syncQ[1] == stableLvl) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_LAST) begin
        stableLvl  <= syncQ[1];
        holdCnt    <= '0;
        pressPulse <= syncQ[1];
      end else begin
        holdCnt <= holdCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int PRESC_BITS      = 15,
  parameter int DEBOUNCE_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refEn,
  input  logic       setMode,
  input  logic       btnMinRaw,
  input  logic       btnHourRaw,
  output todStrobe_t strobes
);
  localparam int NUM_BTN = 2;

  logic [PRESC_BITS-1:0] presc;
  logic [NUM_BTN-1:0]    btnRaw;
  logic [NUM_BTN-1:0]    pressPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc <= '0;
    end else if (refEn) begin
      presc <= presc + PRESC_BITS'(1);
    end
  end

  assign btnRaw = {btnHourRaw, btnMinRaw};

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    tod_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk       (clk),
      .rst       (rst),
      .btnRaw    (btnRaw[b]),
      .pressPulse(pressPulse[b])
    );
  end

  always_comb begin
    strobes.secTick   = refEn && (presc == '1);
    strobes.carryEn   = !setMode;
    strobes.minPress  = setMode && pressPulse[0];
    strobes.hourPress = setMode && pressPulse[1];
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  todStrobe_t  strobes,
  output logic [23:0] timeBcd,
  output logic        secStrobe
);
  localparam int NUM_FIELDS = 3;
  // index 0 = seconds, 1 = minutes, 2 = hours
  localparam logic [7:0] FIELD_LAST [NUM_FIELDS] = '{8'h59, 8'h59, 8'h23};

  logic [7:0]            fieldVal [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldAdv;
  logic secAdv, secWrap, minAdv, minWrap, hourAdv;

  always_comb begin
    secAdv  = strobes.secTick;
    secWrap = secAdv && (fieldVal[0] == FIELD_LAST[0]);
    minAdv  = strobes.carryEn ? secWrap : strobes.minPress;
    minWrap = minAdv && (fieldVal[1] == FIELD_LAST[1]);
    hourAdv = strobes.carryEn ? minWrap : strobes.hourPress;
  end

  assign fieldAdv = {hourAdv, minAdv, secAdv};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        fieldVal[g] <= 8'h00;
      end else if (fieldAdv[g]) begin
        fieldVal[g] <= bcdStep(fieldVal[g], FIELD_LAST[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secStrobe <= 1'b0;
    end else begin
      secStrobe <= secAdv;
    end
  end

  assign timeBcd = {fieldVal[2], fieldVal[1], fieldVal[0]};
endmodule

// File: rtl/bcd_tod_counter.sv
module bcd_tod_counter
  import tod_pkg::*;
#(
  parameter int PRESC_BITS      = 15,
  parameter int DEBOUNCE_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        refEn,
  input  logic        setMode,
  input  logic        btnMinRaw,
  input  logic        btnHourRaw,
  output logic [23:0] timeBcd,
  output logic        secStrobe
);
  todStrobe_t ctrlStrobes;

  tod_ctrl #(
    .PRESC_BITS     (PRESC_BITS),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .refEn     (refEn),
    .setMode   (setMode),
    .btnMinRaw (btnMinRaw),
    .btnHourRaw(btnHourRaw),
    .strobes   (ctrlStrobes)
  );

  tod_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (ctrlStrobes),
    .timeBcd  (timeBcd),
    .secStrobe(secStrobe)
  );
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        setMode,
  input logic [23:0] timeBcd,
  input logic        secStrobe,
  input todStrobe_t  strobes
);
  // R7: every digit in its legal range
  p_digit_range_r7: assert property (@(posedge clk) disable iff (rst)
    (timeBcd[3:0] <= 4'd9) && (timeBcd[7:4] <= 4'd5) &&
    (timeBcd[11:8] <= 4'd9) && (timeBcd[15:12] <= 4'd5) &&
    (timeBcd[19:16] <= 4'd9) && (timeBcd[23:16] <= 8'h23));

  // R3: strobe only with a change of seconds, and seconds only change with strobe
  p_strobe_change_r3: assert property (@(posedge clk) disable iff (rst)
    secStrobe |-> (timeBcd[7:0] != $past(timeBcd[7:0])));
  p_strobe_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !secStrobe |-> $stable(timeBcd[7:0]));

  // R8: in set mode the corrected fields only move on a press
  p_min_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(setMode) && !$past(strobes.minPress)) |-> $stable(timeBcd[15:8]));
  p_hour_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(setMode) && !$past(strobes.hourPress)) |-> $stable(timeBcd[23:16]));

  // R12: in run mode the time only moves on a second tick
  p_run_ignore_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(setMode) && !$past(strobes.secTick)) |-> $stable(timeBcd));

  // R11: accepted presses are single-cycle pulses
  p_min_single_r11: assert property (@(posedge clk) disable iff (rst)
    strobes.minPress |=> !strobes.minPress);
  p_hour_single_r11: assert property (@(posedge clk) disable iff (rst)
    strobes.hourPress |=> !strobes.hourPress);
endmodule

bind bcd_tod_counter tod_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .setMode  (setMode),
  .timeBcd  (timeBcd),
  .secStrobe(secStrobe),
  .strobes  (ctrlStrobes)
);

// File: tb/bcd_tod_counter_tb.sv
module bcd_tod_counter_tb;
  localparam int PB  = 2;
  localparam int DEB = 4;
  localparam int PULSES_PER_SEC = 2 ** PB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refEn = 1'b0;
  logic        setMode = 1'b0;
  logic        btnMinRaw = 1'b0;
  logic        btnHourRaw = 1'b0;
  logic [23:0] timeBcd;
  logic        secStrobe;

  int nChecks = 0;
  int nFail   = 0;
  int eh = 0, em = 0, es = 0;

  always #10 clk = ~clk;

  bcd_tod_counter #(.PRESC_BITS(PB), .DEBOUNCE_CYCLES(DEB)) u_dut (
    .clk(clk), .rst(rst), .refEn(refEn), .setMode(setMode),
    .btnMinRaw(btnMinRaw), .btnHourRaw(btnHourRaw),
    .timeBcd(timeBcd), .secStrobe(secStrobe)
  );

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R7 layout: hour tens, hour units, minute tens, minute units, second tens, second units
  function automatic logic [23:0] expTime();
    return {4'(eh / 10), 4'(eh % 10), 4'(em / 10), 4'(em % 10), 4'(es / 10), 4'(es % 10)};
  endfunction

  function automatic void hourStep();
    eh = (eh + 1) % 24;
  endfunction

  function automatic void minStep(input bit carry);
    if (em == 59) begin
      em = 0;
      if (carry) hourStep();
    end else em++;
  endfunction

  function automatic void secStep(input bit carry);
    if (es == 59) begin
      es = 0;
      if (carry) minStep(carry);
    end else es++;
  endfunction

  task automatic refPulse();
    refEn = 1'b1;
    @(negedge clk);
    refEn = 1'b0;
  endtask

  task automatic oneSecond(input string tag);
    for (int p = 0; p < PULSES_PER_SEC; p++) refPulse();
    secStep(!setMode);
    check(tag, timeBcd, expTime());
    check("R3 strobe high", {23'b0, secStrobe}, 24'd1);
    @(negedge clk);
    check("R3 strobe low", {23'b0, secStrobe}, 24'd0);
  endtask

  task automatic press(input bit hourBtn);
    if (hourBtn) btnHourRaw = 1'b1; else btnMinRaw = 1'b1;
    repeat (DEB + 6) @(negedge clk);
    btnHourRaw = 1'b0;
    btnMinRaw  = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    if (setMode) begin
      if (hourBtn) hourStep(); else minStep(1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset time", timeBcd, 24'h000000);
    check("R1 reset strobe", {23'b0, secStrobe}, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", timeBcd, 24'h000000);

    // R2: exact pulse count per second
    for (int p = 0; p < PULSES_PER_SEC - 1; p++) begin
      refPulse();
      check("R2 no advance early", timeBcd, 24'h000000);
    end
    refPulse();
    es = 1;
    check("R2 advance on last pulse", timeBcd, expTime());
    check("R3 strobe high", {23'b0, secStrobe}, 24'd1);
    @(negedge clk);
    check("R3 strobe low", {23'b0, secStrobe}, 24'd0);

    // R4 R5: sweep one hour in run mode
    for (int s = 0; s < 3600; s++) oneSecond("R4 R5 run sweep");
    check("R5 reached hour one", timeBcd, 24'h010001);

    // R9: minute presses in set mode, through 59 -> 00
    setMode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      press(1'b0);
      check("R9 minute press", timeBcd, expTime());
    end
    // R10: hour presses, through 23 -> 00
    for (int k = 0; k < 23; k++) begin
      press(1'b1);
      check("R10 hour press", timeBcd, expTime());
    end

    // R8: carries cut in set mode
    for (int k = 0; k < 59; k++) press(1'b0);
    check("R8 minutes set to 59", timeBcd, expTime());
    for (int s = 0; s < 61; s++) oneSecond("R8 set-mode seconds");
    check("R8 minutes held", {8'h00, timeBcd[23:8]}, {8'h00, 16'h0059});

    // R11: short chatter is rejected
    for (int g = 0; g < 5; g++) begin
      btnMinRaw = 1'b1;
      repeat (2) @(negedge clk);
      btnMinRaw = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (DEB + 6) @(negedge clk);
    check("R11 chatter ignored", timeBcd, expTime());
    // R11: bouncing press counts once
    for (int g = 0; g < 3; g++) begin
      btnHourRaw = 1'b1;
      @(negedge clk);
      btnHourRaw = 1'b0;
      @(negedge clk);
    end
    btnHourRaw = 1'b1;
    repeat (DEB + 6) @(negedge clk);
    btnHourRaw = 1'b0;
    @(negedge clk);
    btnHourRaw = 1'b1;
    @(negedge clk);
    btnHourRaw = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    hourStep();
    check("R11 bouncy press single count", timeBcd, expTime());

    // R12: buttons ignored in run mode
    setMode = 1'b0;
    press(1'b0);
    check("R12 minute button ignored", timeBcd, expTime());
    press(1'b1);
    check("R12 hour button ignored", timeBcd, expTime());

    // R6: midnight wrap from 23:59
    setMode = 1'b1;
    for (int k = 0; k < 22; k++) press(1'b1);
    check("R10 hour set to 23", timeBcd[23:16], 8'h23);
    setMode = 1'b0;
    for (int s = 0; s < 61; s++) oneSecond("R6 midnight run");
    check("R6 wrapped to 00", {16'h0, timeBcd[23:16]}, 24'h000000);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule